// File: doc/BRIEF.md
# ADC Result Bank with Threshold Compare

This block sits behind an analog-to-digital converter and collects the outcome of each conversion in a sequence. Each conversion carries its slot number (0 to 11) within the sequence, not the input channel number. For every slot, software chooses one of two uses for that slot's 16-bit register. In the first, the register receives the 10-bit unsigned result, aligned left or right as the current justification mode says. In the second, the register holds a threshold. The result is then compared against it and thrown away, and only a per-slot status flag records the outcome.

A synchronous register port gives software access to the twelve slot registers, the per-slot compare enable, the per-slot operator select and the write-one-to-clear status flags. Writing the operator select register raises a one-cycle abort pulse, which tells the sequencer to drop the conversion sequence in progress. Register reads are combinational from the address.

Address map: 0 to 11 are the slot registers, 12 is compare enable, 13 is operator select, 14 is compare flags, and 15 is reserved.

Top module: `adc_result_bank`

## Requirements
- R1: After reset, every address reads zero and `seqAbort` is low.
- R2: A write to addresses 0 to 11 stores all 16 bits. Addresses 12 and 13 store bits 11..0. Each is readable at any time.
- R3: A result event for slot n whose compare enable bit n is 0 writes the result into slot register n on the clock edge that accepts it. With `leftJust`=0, the value sits in bits 9..0 and bits 15..10 are zero.
- R4: With `leftJust`=1, a stored result sits in bits 15..6 and bits 5..0 are zero.
- R5: A result event with slot index 12 to 15 changes no register and no flag.
- R6: A result event for slot n whose compare enable bit n is 1 leaves slot register n unchanged.
- R7: For a compared slot n, flag bit n (address 14) is set when operator bit n is 1 and result > threshold, or when operator bit n is 0 and result <= threshold. When the test fails, the flag keeps its value.
- R8: The threshold is the slot register's bits 9..0 when `leftJust`=0 and its bits 15..6 when `leftJust`=1.
- R9: Writing address 14 clears each flag whose write-data bit is 1 and keeps the others. A flag set in the same cycle wins over the clear.
- R10: A write to address 13 drives `seqAbort` high for exactly the one cycle after the write edge. No other activity raises it.
- R11: Bits 15..12 of addresses 12, 13 and 14 read zero. Address 15 reads zero and ignores writes.
- R12: When a software write and a stored result target the same slot in the same cycle, the stored result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for read and write |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Read data for `regAddr`, combinational |
| resValid | input | 1 | Conversion result valid, one cycle per result |
| resIdx | input | 4 | Slot number of the result within the sequence |
| resData | input | 10 | Unsigned conversion result |
| leftJust | input | 1 | Justification mode: 1 left, 0 right |
| seqAbort | output | 1 | One-cycle sequence abort pulse |

## Verification
A wrong store path or wrong alignment shows on the read port one cycle after the result event, as soon as software reads that slot. A wrong compare enable or operator decode shows in two ways: a compared slot's threshold gets overwritten, or a flag bit is set or left clear when it should not be. A wrong threshold alignment only shows when the alignment changes the outcome of the comparison, so the stimulus mixes both modes over thresholds and results drawn near each other. A stray or missing abort shows on `seqAbort` in the very next cycle.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;
  localparam int NUM_SLOTS  = 12;
  localparam int IDX_W      = 4;
  localparam int WORD_W     = 16;
  localparam int RES_W      = 10;
  localparam int ADDR_W     = 4;
  localparam int PAD_W      = WORD_W - RES_W;
  localparam int ADDR_CMPEN = 12;
  localparam int ADDR_OPER  = 13;
  localparam int ADDR_FLAGS = 14;

  // strobes from control to datapath, one bit per slot
  typedef struct packed {
    logic [NUM_SLOTS-1:0] swWrite;
    logic [NUM_SLOTS-1:0] hwStore;
  } bankStrobe_t;
endpackage

// File: rtl/adc_bank_dp.sv
module adc_bank_dp
  import adc_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStrobe_t          strobe,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [RES_W-1:0]     resData,
  input  logic                 leftJust,
  input  logic [NUM_SLOTS-1:0] operSel,
  input  logic [ADDR_W-1:0]    rdIdx,
  output logic [WORD_W-1:0]    rdWord,
  output logic [NUM_SLOTS-1:0] cmpHit
);
  logic [WORD_W-1:0] slotQ [NUM_SLOTS];
  logic [WORD_W-1:0] alignedRes;

  always_comb begin
    if (leftJust) alignedRes = {resData, {PAD_W{1'b0}}};
    else          alignedRes = {{PAD_W{1'b0}}, resData};
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [RES_W-1:0] thresh;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   slotQ[i] <= '0;
      else if (strobe.hwStore[i])  slotQ[i] <= alignedRes;
      else if (strobe.swWrite[i])  slotQ[i] <= wrData;
    end

    always_comb begin
      if (leftJust) thresh = slotQ[i][WORD_W-1:PAD_W];
      else          thresh = slotQ[i][RES_W-1:0];
      if (operSel[i]) cmpHit[i] = resData >  thresh;
      else            cmpHit[i] = resData <= thresh;
    end
  end

  always_comb begin
    rdWord = '0;
    for (int k = 0; k < NUM_SLOTS; k++)
      if (rdIdx == ADDR_W'(k)) rdWord = slotQ[k];
  end
endmodule

// File: rtl/adc_bank_ctrl.sv
module adc_bank_ctrl
  import adc_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [WORD_W-1:0]    regWdata,
  input  logic                 resValid,
  input  logic [IDX_W-1:0]     resIdx,
  input  logic [NUM_SLOTS-1:0] cmpHit,
  input  logic [WORD_W-1:0]    dpWord,
  output bankStrobe_t          strobe,
  output logic [NUM_SLOTS-1:0] cmpEnQ,
  output logic [NUM_SLOTS-1:0] operQ,
  output logic [NUM_SLOTS-1:0] flagQ,
  output logic [WORD_W-1:0]    regRdata,
  output logic                 seqAbort
);
  localparam int HI_W = WORD_W - NUM_SLOTS;

  logic [NUM_SLOTS-1:0] flagSet;
  logic                 wrEn, wrOper, wrFlags;

  assign wrEn    = regWe && (regAddr == ADDR_W'(ADDR_CMPEN));
  assign wrOper  = regWe && (regAddr == ADDR_W'(ADDR_OPER));
  assign wrFlags = regWe && (regAddr == ADDR_W'(ADDR_FLAGS));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_dec
    logic hitSlot;
    assign hitSlot            = resValid && (resIdx == IDX_W'(i));
    assign strobe.swWrite[i]  = regWe && (regAddr == ADDR_W'(i));
    assign strobe.hwStore[i]  = hitSlot && !cmpEnQ[i];
    assign flagSet[i]         = hitSlot && cmpEnQ[i] && cmpHit[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpEnQ   <= '0;
      operQ    <= '0;
      flagQ    <= '0;
      seqAbort <= 1'b0;
    end else begin
      if (wrEn)   cmpEnQ <= regWdata[NUM_SLOTS-1:0];
      if (wrOper) operQ  <= regWdata[NUM_SLOTS-1:0];
      flagQ    <= (wrFlags ? (flagQ & ~regWdata[NUM_SLOTS-1:0]) : flagQ) | flagSet;
      seqAbort <= wrOper;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_W'(ADDR_CMPEN): regRdata = {{HI_W{1'b0}}, cmpEnQ};
      ADDR_W'(ADDR_OPER):  regRdata = {{HI_W{1'b0}}, operQ};
      ADDR_W'(ADDR_FLAGS): regRdata = {{HI_W{1'b0}}, flagQ};
      default:             regRdata = dpWord;
    endcase
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [3:0]        regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  input  logic              resValid,
  input  logic [3:0]        resIdx,
  input  logic [9:0]        resData,
  input  logic              leftJust,
  output logic              seqAbort
);
  bankStrobe_t          strobe;
  logic [NUM_SLOTS-1:0] cmpHit, cmpEnQ, operQ, flagQ;
  logic [WORD_W-1:0]    dpWord;

  adc_bank_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .resValid(resValid), .resIdx(resIdx), .cmpHit(cmpHit), .dpWord(dpWord),
    .strobe(strobe), .cmpEnQ(cmpEnQ), .operQ(operQ), .flagQ(flagQ),
    .regRdata(regRdata), .seqAbort(seqAbort)
  );

  adc_bank_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWdata), .resData(resData),
    .leftJust(leftJust), .operSel(operQ), .rdIdx(regAddr), .rdWord(dpWord),
    .cmpHit(cmpHit)
  );
endmodule

// File: rtl/adc_bank_checker.sv
module adc_bank_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [3:0]  regAddr,
  input logic [15:0] regWdata,
  input logic [15:0] regRdata,
  input logic        resValid,
  input logic [3:0]  resIdx,
  input logic [9:0]  resData,
  input logic        leftJust,
  input logic        seqAbort,
  input logic [11:0] cmpEnQ,
  input logic [11:0] flagQ
);
  logic [15:0] enWide;
  logic        slotEvt, wrOperNow, wrFlagNow;
  assign enWide    = {4'b0, cmpEnQ};
  assign slotEvt   = resValid && (resIdx < 4'd12) && (resIdx == regAddr);
  assign wrOperNow = regWe && (regAddr == 4'd13);
  assign wrFlagNow = regWe && (regAddr == 4'd14);

  a_r10_abort_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wrOperNow |=> seqAbort);
  a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrOperNow |=> !seqAbort);
  a_r3_store_right: assert property (@(posedge clk) disable iff (!rstN)
    (slotEvt && !enWide[resIdx] && !leftJust) |=>
      ($stable(regAddr) -> (regRdata == {6'b0, $past(resData)})));
  a_r4_store_left: assert property (@(posedge clk) disable iff (!rstN)
    (slotEvt && !enWide[resIdx] && leftJust) |=>
      ($stable(regAddr) -> (regRdata == {$past(resData), 6'b0})));
  a_r6_threshold_kept: assert property (@(posedge clk) disable iff (!rstN)
    (slotEvt && enWide[resIdx] && !regWe) |=>
      ($stable(regAddr) -> $stable(regRdata)));
  a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !wrFlagNow |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  always_comb begin
    if (rstN && (regAddr >= 4'd12))
      a_r11_upper_zero: assert (regRdata[15:12] == 4'b0);
  end
endmodule

bind adc_result_bank adc_bank_checker i_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .regRdata(regRdata), .resValid(resValid), .resIdx(resIdx), .resData(resData),
  .leftJust(leftJust), .seqAbort(seqAbort), .cmpEnQ(cmpEnQ), .flagQ(flagQ)
);

// File: tb/test_adc_result_bank.sv
module test_adc_result_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        resValid = 1'b0;
  logic [3:0]  resIdx = '0;
  logic [9:0]  resData = '0;
  logic        leftJust = 1'b0;
  logic        seqAbort;

  int nTests = 0;
  int nFail  = 0;

  logic [15:0] mSlot [12];
  logic [11:0] mEn, mOp, mFlag;
  logic        mAbort;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_bank i_adc_result_bank (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .resValid(resValid), .resIdx(resIdx), .resData(resData),
    .leftJust(leftJust), .seqAbort(seqAbort)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] align(input logic [9:0] d, input logic lj);
    return lj ? {d, 6'b0} : {6'b0, d};
  endfunction

  function automatic logic [15:0] modelRead(input logic [3:0] a);
    if (a < 4'd12)  return mSlot[a];
    if (a == 4'd12) return {4'b0, mEn};
    if (a == 4'd13) return {4'b0, mOp};
    if (a == 4'd14) return {4'b0, mFlag};
    return 16'h0;
  endfunction

  function automatic string tagFor(input logic [3:0] a);
    if (a < 4'd12)  return "R3";
    if (a == 4'd14) return "R9";
    if (a == 4'd15) return "R11";
    return "R2";
  endfunction

  // one clock: optional register write and optional result event
  task automatic step(input logic we, input logic [3:0] a, input logic [15:0] wd,
                      input logic v, input logic [3:0] idx, input logic [9:0] d,
                      input logic lj);
    logic [15:0] nSlot [12];
    logic [11:0] nEn, nOp, nFlag, setV;
    logic [9:0]  thr;
    logic        hit;
    @(negedge clk);
    regWe = we; regAddr = a; regWdata = wd;
    resValid = v; resIdx = idx; resData = d; leftJust = lj;
    for (int k = 0; k < 12; k++) nSlot[k] = mSlot[k];
    nEn = mEn; nOp = mOp; setV = '0;
    if (we && a < 4'd12)  nSlot[a] = wd;
    if (we && a == 4'd12) nEn = wd[11:0];
    if (we && a == 4'd13) nOp = wd[11:0];
    nFlag = (we && a == 4'd14) ? (mFlag & ~wd[11:0]) : mFlag;
    if (v && idx < 4'd12) begin
      if (mEn[idx]) begin
        thr = lj ? mSlot[idx][15:6] : mSlot[idx][9:0];
        hit = mOp[idx] ? (d > thr) : (d <= thr);
        setV[idx] = hit;
      end else begin
        nSlot[idx] = align(d, lj);
      end
    end
    nFlag = nFlag | setV;
    @(posedge clk);
    #1;
    regWe = 1'b0; resValid = 1'b0;
    for (int k = 0; k < 12; k++) mSlot[k] = nSlot[k];
    mEn = nEn; mOp = nOp; mFlag = nFlag;
    mAbort = we && (a == 4'd13);
    check("R10 seqAbort", {15'b0, seqAbort}, {15'b0, mAbort});
  endtask

  task automatic readCheck(input logic [3:0] a, input string tag);
    regAddr = a;
    #1;
    check(tag, regRdata, modelRead(a));
  endtask

  task automatic readAll(input string tag);
    for (int a = 0; a < 16; a++) readCheck(4'(a), tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int unsigned seed;
    for (int k = 0; k < 12; k++) mSlot[k] = '0;
    mEn = '0; mOp = '0; mFlag = '0; mAbort = 1'b0;
    seed = 32'h1d2c3b4a;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    #1;
    check("R1 seqAbort after reset", {15'b0, seqAbort}, 16'h0);
    readAll("R1 reset readback");
    rstN = 1'b1;

    // R2: full-width storage, partial-width control registers
    step(1, 4'd5, 16'hBEEF, 0, 0, 0, 0);
    readCheck(4'd5, "R2 slot write");
    step(1, 4'd12, 16'hFFFF, 0, 0, 0, 0);
    readCheck(4'd12, "R2 R11 enable width");
    step(1, 4'd12, 16'h0000, 0, 0, 0, 0);
    // R11: reserved address ignores writes
    step(1, 4'd15, 16'hFFFF, 0, 0, 0, 0);
    readCheck(4'd15, "R11 reserved");
    // R3 / R4 stores
    step(0, 0, 0, 1, 4'd2, 10'h3A5, 0);
    readCheck(4'd2, "R3 right justified");
    step(0, 0, 0, 1, 4'd11, 10'h3A5, 1);
    readCheck(4'd11, "R4 left justified");
    // R5: out-of-range slot index
    step(0, 0, 0, 1, 4'd13, 10'h155, 0);
    readAll("R5 ignored index");
    // R12: store beats software write
    step(1, 4'd7, 16'h1234, 1, 4'd7, 10'h0F0, 0);
    readCheck(4'd7, "R12 store wins");
    // R10: abort pulse only for one cycle
    step(1, 4'd13, 16'h0001, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    // R6 / R7 / R8: slot 0 compare, higher-than, threshold 0x200 in left form
    step(1, 4'd0, 16'h8000, 0, 0, 0, 0);
    step(1, 4'd12, 16'h0001, 0, 0, 0, 0);
    step(0, 0, 0, 1, 4'd0, 10'h1FF, 1);
    readCheck(4'd14, "R7 no hit below");
    readCheck(4'd0, "R6 threshold kept");
    step(0, 0, 0, 1, 4'd0, 10'h201, 0);
    readCheck(4'd14, "R8 right threshold 0");
    step(1, 4'd14, 16'h0FFF, 0, 0, 0, 0);
    step(0, 0, 0, 1, 4'd0, 10'h200, 1);
    readCheck(4'd14, "R7 equal not higher");
    step(0, 0, 0, 1, 4'd0, 10'h201, 1);
    readCheck(4'd14, "R7 R8 higher left");
    // R9: clear with zero bit keeps, set wins over clear
    step(1, 4'd14, 16'h0000, 0, 0, 0, 0);
    readCheck(4'd14, "R9 zero keeps");
    step(1, 4'd14, 16'h0001, 1, 4'd0, 10'h3FF, 1);
    readCheck(4'd14, "R9 set beats clear");
    step(1, 4'd14, 16'h0001, 0, 0, 0, 0);
    readCheck(4'd14, "R9 clear");

    // constrained random mix
    for (int it = 0; it < 1500; it++) begin
      logic [3:0]  a, idx;
      logic [15:0] wd;
      logic        we, v, lj;
      logic [9:0]  d;
      int          sel;
      sel = int'($urandom_range(0, 9));
      a   = 4'($urandom_range(0, 15));
      idx = 4'($urandom_range(0, 13));
      lj  = 1'($urandom);
      we  = (sel < 5);
      v   = (sel >= 3);
      wd  = 16'($urandom);
      if (a == 4'd13 && sel != 0) a = 4'd12;
      if (idx < 4'd12 && mEn[idx] && (sel & 1) == 1) begin
        d = lj ? mSlot[idx][15:6] : mSlot[idx][9:0];
        d = d + 10'($urandom_range(0, 2)) - 10'd1;
      end else begin
        d = 10'($urandom);
      end
      step(we, a, wd, v, idx, d, lj);
      a = 4'($urandom_range(0, 15));
      readCheck(a, tagFor(a));
    end
    readAll("R2 R3 R9 final readback");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule